// File: doc/BRIEF.md
# Serial EEPROM Bit-Bang Port

This block gives host software direct, pin-level control of a serial configuration EEPROM through a small register window. A control register holds the clock, data-in, chip-select and shift-busy levels together with a master enable. A second address, the pin port, lets software toggle the EEPROM clock and data with one write and sample the EEPROM data output with one read. While the enable bit is clear, the EEPROM pins are released to zero and any write that would move them is dropped. The exception is the shift-busy line, which keeps the last level programmed.

Software can also request an automatic configuration reload. A timed sequencer models that reload. It holds a busy output high for a parameterized number of clock cycles, equal to 1.4 ms at the chosen clock by default. During that interval every register access is refused: there is no acknowledge, reads return nothing and writes have no effect. When the interval ends, the load flag returns to zero by itself.

Top module: `eeprom_port`

## Requirements
- R1: After reset, all EEPROM outputs, the shift-busy pin and the reload busy output are 0. A control-register read returns 0 in bits 7:1.
- R2: The control register (address 0) has this layout: bit 0 is data, bit 1 is clock, bit 2 is chip-select, bit 3 is shift-busy, bit 4 is enable, bit 5 is load, and bits 7:6 are reserved. A write with bit 4 = 1 and bit 5 = 0 stores all of bits 4:0.
- R3: A control write with bit 4 = 0 and bit 5 = 0 clears the enable bit and leaves the stored clock, data, chip-select and shift-busy bits unchanged.
- R4: `ee_sk`, `ee_di` and `ee_cs` follow their stored bits while enable is 1, and they are 0 while enable is 0.
- R5: `shf_busy` follows the stored shift-busy bit. It keeps its last programmed level after enable is cleared.
- R6: Bit 0 of a control-register read returns the `ee_do` input, not the stored data bit.
- R7: A pin-port write (address 1) with enable = 1 sets the clock from bit 0 and the data from bit 1. A pin-port read returns clock in bit 0, data in bit 1 and `ee_do` in bit 2. With enable = 0, pin-port writes are ignored and pin-port reads return 0.
- R8: Reserved bits read as 0 whatever value is written to them.
- R9: A control write with bit 5 = 1 starts a reload and changes no other stored bit. `load_busy` is then high for exactly LOAD_CYCLES cycles (CLK_MHZ*LOAD_US), after which bit 5 reads 0.
- R10: While `load_busy` is high, `bus_ack` stays 0 and register writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = control register, 1 = pin port |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access accepted this cycle |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM data input |
| ee_cs | output | 1 | EEPROM chip select |
| ee_do | input | 1 | EEPROM data output |
| shf_busy | output | 1 | Shift-busy pin |
| load_busy | output | 1 | Reload in progress |

## Verification
The hardest case to reach is a write attempted in the middle of a reload. The block gives no acknowledge then, so the bench can only see the result after the reload ends. The bench starts a reload and tries a control write that would set enable and chip-select. It counts the busy cycles while it polls for the absent acknowledge. Once the reload is over, it reads the register back to confirm that the attempted write left no trace. The hold of shift-busy across a disable needs a similar ordering: the bench sets the pin first, then clears enable with a zero in the shift-busy bit, and only after that checks the pin.

// File: rtl/eeprom_port_pkg.sv
package eeprom_port_pkg;

    localparam int BIT_DAT  = 0;
    localparam int BIT_SK   = 1;
    localparam int BIT_CS   = 2;
    localparam int BIT_SHFB = 3;
    localparam int BIT_EN   = 4;
    localparam int BIT_LOAD = 5;

    localparam int PORT_SK  = 0;
    localparam int PORT_DI  = 1;
    localparam int PORT_DO  = 2;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_PORT = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic en;
        logic shfb;
        logic cs;
        logic sk;
        logic dat;
    } pin_state_t;

    function automatic logic [7:0] ctrl_image(pin_state_t s, logic busy, logic dout);
        logic [7:0] v;
        v = '0;
        v[BIT_DAT]  = dout;
        v[BIT_SK]   = s.sk;
        v[BIT_CS]   = s.cs;
        v[BIT_SHFB] = s.shfb;
        v[BIT_EN]   = s.en;
        v[BIT_LOAD] = busy;
        return v;
    endfunction

    function automatic logic [7:0] port_image(pin_state_t s, logic dout);
        logic [7:0] v;
        v = '0;
        if (s.en) begin
            v[PORT_SK] = s.sk;
            v[PORT_DI] = s.dat;
            v[PORT_DO] = dout;
        end
        return v;
    endfunction

endpackage

// File: rtl/eeprom_ctrl_reg.sv
module eeprom_ctrl_reg
    import eeprom_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_port,
    input  logic [DW-1:0] wdata,
    output pin_state_t    state,
    output logic          load_start
);

    pin_state_t state_q;

    assign load_start = wr_ctrl && wdata[BIT_LOAD];
    assign state      = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (wr_ctrl && !wdata[BIT_LOAD]) begin
            state_q.en <= wdata[BIT_EN];
            if (wdata[BIT_EN]) begin
                state_q.dat  <= wdata[BIT_DAT];
                state_q.sk   <= wdata[BIT_SK];
                state_q.cs   <= wdata[BIT_CS];
                state_q.shfb <= wdata[BIT_SHFB];
            end
        end else if (wr_port && state_q.en) begin
            state_q.sk  <= wdata[PORT_SK];
            state_q.dat <= wdata[PORT_DI];
        end
    end

    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
        (!(wr_ctrl && wdata[BIT_EN]) && !(wr_port && state_q.en))
        |=> ($stable(state_q.cs) && $stable(state_q.sk) && $stable(state_q.shfb)));

    a_r9_load_write_pure: assert property (@(posedge clk) disable iff (rst)
        load_start |=> $stable(state_q));

endmodule

// File: rtl/eeprom_reload_seq.sv
module eeprom_reload_seq #(
    parameter int LOAD_CYCLES = 175000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(LOAD_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(LOAD_CYCLES - 1);
        end
    end

    assign busy = busy_q;

    a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> busy_q);

    a_r9_count_in_range: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (int'(cnt_q) < LOAD_CYCLES));

    a_r9_ends_at_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(cnt_q) == '0));

endmodule

// File: rtl/eeprom_pin_drv.sv
module eeprom_pin_drv
    import eeprom_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  pin_state_t    state,
    input  logic          busy,
    input  logic          ee_do,
    input  logic          rd_addr,
    output logic          ee_sk,
    output logic          ee_di,
    output logic          ee_cs,
    output logic          shf_busy,
    output logic [DW-1:0] rdata
);

    logic [7:0] img;

    always_comb begin
        ee_sk    = state.en & state.sk;
        ee_di    = state.en & state.dat;
        ee_cs    = state.en & state.cs;
        shf_busy = state.shfb;
        if (reg_addr_e'(rd_addr) == ADDR_CTRL) img = ctrl_image(state, busy, ee_do);
        else                                   img = port_image(state, ee_do);
    end

    generate
        if (DW > 8) begin : g_wide
            assign rdata = {{(DW-8){1'b0}}, img};
        end else begin : g_narrow
            assign rdata = img[DW-1:0];
        end
    endgenerate

endmodule

// File: rtl/eeprom_port.sv
module eeprom_port
    import eeprom_port_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CLK_MHZ = 125,
    parameter int LOAD_US = 1400
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ack,
    output logic          ee_sk,
    output logic          ee_di,
    output logic          ee_cs,
    input  logic          ee_do,
    output logic          shf_busy,
    output logic          load_busy
);

    localparam int LOAD_CYCLES = CLK_MHZ * LOAD_US;

    pin_state_t state;
    logic       load_start;
    logic       wr_ok;
    logic       wr_ctrl;
    logic       wr_port;

    assign bus_ack = (bus_wr || bus_rd) && !load_busy;
    assign wr_ok   = bus_wr && !load_busy;
    assign wr_ctrl = wr_ok && (reg_addr_e'(bus_addr) == ADDR_CTRL);
    assign wr_port = wr_ok && (reg_addr_e'(bus_addr) == ADDR_PORT);

    eeprom_ctrl_reg #(.DW(DW)) u_reg (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_port(wr_port),
        .wdata(bus_wdata), .state(state), .load_start(load_start)
    );

    eeprom_reload_seq #(.LOAD_CYCLES(LOAD_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .start(load_start), .busy(load_busy)
    );

    eeprom_pin_drv #(.DW(DW)) u_drv (
        .state(state), .busy(load_busy), .ee_do(ee_do), .rd_addr(bus_addr),
        .ee_sk(ee_sk), .ee_di(ee_di), .ee_cs(ee_cs), .shf_busy(shf_busy),
        .rdata(bus_rdata)
    );

    a_r10_no_ack_in_load: assert property (@(posedge clk) disable iff (rst)
        load_busy |-> !bus_ack);

    a_r10_pins_still_in_load: assert property (@(posedge clk) disable iff (rst)
        (load_busy && $past(load_busy)) |-> ($stable(ee_cs) && $stable(shf_busy)));

    a_r5_shfb_held_on_disable: assert property (@(posedge clk) disable iff (rst)
        $fell(state.en) |-> $stable(shf_busy));

    a_r4_pins_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !state.en |-> (!ee_sk && !ee_di && !ee_cs));

endmodule

// File: tb/eeprom_port_tb.sv
`timescale 1ns/1ps
module eeprom_port_tb;

    localparam int DW = 8;
    localparam int LOAD_CYC = 125;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ack, ee_sk, ee_di, ee_cs, shf_busy, load_busy;
    logic          ee_do = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;

    eeprom_port #(.DW(DW), .CLK_MHZ(125), .LOAD_US(1)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .ee_sk(ee_sk), .ee_di(ee_di), .ee_cs(ee_cs),
        .ee_do(ee_do), .shf_busy(shf_busy), .load_busy(load_busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [DW-1:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pins(input logic sk, input logic di, input logic cs, input logic sb, input string tag);
        @(negedge clk); #2;
        check(tag, {ee_sk, ee_di, ee_cs, shf_busy}, {sk, di, cs, sb});
    endtask

    // monitor: pops expected read data when an acknowledged read is seen
    initial forever begin
        @(negedge clk); #3;
        if (bus_rd && bus_ack) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    initial begin
        #1_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int busy_n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        pins(0, 0, 0, 0, "R1 pins after reset");
        check("R1 busy after reset", load_busy, 0);
        rd(0, 8'h00, "R1 ctrl after reset");
        // R2 R4 enable with cs, sk, dat set
        wr(0, 8'b0001_0111);
        pins(1, 1, 1, 0, "R4 pins follow when enabled");
        rd(0, 8'b0001_0110, "R2 ctrl readback (do=0)");
        // R6 bit0 returns DO
        ee_do = 1'b1;
        rd(0, 8'b0001_0111, "R6 bit0 reflects ee_do=1");
        wr(0, 8'b0001_0100);
        rd(0, 8'b0001_0101, "R6 bit0 is do, not stored data");
        // R7 pin port
        wr(1, 8'b0000_0001);
        pins(1, 0, 1, 0, "R7 port write sk=1 di=0");
        rd(1, 8'b0000_0101, "R7 port read sk,di,do");
        wr(1, 8'b0000_0010);
        pins(0, 1, 1, 0, "R7 port write sk=0 di=1");
        // R5 shift-busy
        wr(0, 8'b0001_1100);
        pins(0, 0, 1, 1, "R5 shfb high when enabled");
        wr(0, 8'b0000_0000);
        pins(0, 0, 0, 1, "R5 shfb held, R4 pins low after disable");
        rd(0, 8'b0000_1101, "R3 stored bits kept after disable");
        // R3 writes while disabled ignored
        wr(0, 8'b0000_0110);
        pins(0, 0, 0, 1, "R3 disabled write leaves pins");
        rd(0, 8'b0000_1101, "R3 disabled write leaves stored bits");
        // R7 port ignored when disabled
        wr(1, 8'b0000_0011);
        rd(1, 8'h00, "R7 port read zero when disabled");
        rd(0, 8'b0000_1101, "R7 port write ignored when disabled");
        // R8 reserved bits
        wr(0, 8'b1101_0000);
        rd(0, 8'b0001_0001, "R8 reserved bits read zero");
        // R9 R10 reload
        wr(0, 8'b0010_0111);
        busy_n = 0;
        @(negedge clk); #2;
        check("R9 busy after load write", load_busy, 1);
        check("R9 load write changes no pin", {ee_sk, ee_di, ee_cs, shf_busy}, 4'b0000);
        bus_rd = 1'b1; bus_addr = 1'b0;
        #1 check("R10 no ack on read in load", bus_ack, 0);
        bus_rd = 1'b0;
        bus_wr = 1'b1; bus_wdata = 8'b0001_0100;
        #1 check("R10 no ack on write in load", bus_ack, 0);
        while (load_busy && busy_n < 10 * LOAD_CYC) begin
            busy_n++;
            @(negedge clk); #2;
        end
        bus_wr = 1'b0;
        check("R9 busy length", busy_n, LOAD_CYC);
        rd(0, 8'b0001_0001, "R9 load clear, R10 write in load ignored");
        @(negedge clk); @(negedge clk);
        check("scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule